// File: doc/BRIEF.md
# Radio Packet Transmit Framer

This block turns one outgoing radio packet into a serial bit stream for a downstream modulator. It builds the alternating preamble, the sync word, a short trailer, an optional header, an optional length byte, the payload bytes read from a show-ahead byte FIFO, and an optional 16-bit checksum. Each bit is offered on a valid/ready handshake, and a one-cycle done pulse marks the end of the packet. Line coding such as whitening, Hamming or Manchester coding is applied by a later stage and is not part of this block.

A host sets the configuration inputs, loads the payload into the FIFO and pulses `start`. The configuration must stay stable while `busy` is high. If the FIFO runs dry while payload bytes are still due, the framer stops offering bits and raises a sticky underflow flag. It resumes without losing bits once data arrives.

Top module: `pkt_tx_framer`

## Requirements
- R1: After a synchronous reset, `bit_valid`, `busy`, `done`, `underflow` and `fifo_pop` are all low.
- R2: The packet opens with (cfg_pre_len+1)*8 preamble bits that alternate, beginning with the inverse of the sync word's top bit. The top bit is cfg_sync bit 8L-1, where L is the sync length in bytes.
- R3: The sync word is 4, 6 or 8 bytes long for cfg_sync_sel = 0, 1 or 2/3. It is taken from the low 8L bits of cfg_sync and sent from bit 8L-1 down to bit 0.
- R4: Four trailer bits follow the sync word. They alternate, beginning with the inverse of cfg_sync bit 0.
- R5: When cfg_hdr_en is 1, a header byte {cfg_pid[1:0], cfg_addr_lo[5:0]} is sent MSB first. When cfg_addr_ext is also 1, cfg_addr_hi[7:0] follows it, MSB first.
- R6: When cfg_len_en is 1, cfg_pay_len is sent MSB first after the header. The payload byte count is cfg_pay_len in every case, and 0 means no payload.
- R7: The payload is cfg_pay_len bytes taken from the FIFO in order, each sent MSB first. `fifo_pop` is high for exactly one cycle per byte and never while `fifo_empty` is high.
- R8: When cfg_crc_en is 1, 16 checksum bits are sent MSB first. The checksum covers the header, length and payload bits. Its register starts at 0xFFFF and takes no final inversion. cfg_crc_fmt 0 selects polynomial 0x1021 (x^16+x^12+x^5+1) and 1 selects 0x8005 (x^16+x^15+x^2+1).
- R9: Exactly one bit advances per cycle in which `bit_valid` and `bit_ready` are both high. While `bit_valid` is high and `bit_ready` is low, `bit_valid` and `bit_data` hold.
- R10: `done` is a one-cycle pulse in the cycle after the last bit is accepted. `busy` is high from the cycle after an accepted `start` until that pulse. A `start` pulse while `busy` is high has no effect on the stream.
- R11: If a payload byte is due while `fifo_empty` is high, the framer stops offering bits once the current bit is taken and sets `underflow`. The flag stays set until the next accepted `start`. Transmission continues with no lost bits once the FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one packet (ignored while busy) |
| cfg_pre_len | input | PRE_W | Preamble length in bytes minus one |
| cfg_sync | input | 64 | Sync word, right-aligned |
| cfg_sync_sel | input | 2 | Sync length select: 0=4, 1=6, 2/3=8 bytes |
| cfg_hdr_en | input | 1 | Send the header |
| cfg_pid | input | 2 | Packet identifier bits of the header |
| cfg_addr_lo | input | 6 | Low address bits of the header |
| cfg_addr_ext | input | 1 | Append the extra address byte |
| cfg_addr_hi | input | 8 | Extra address byte |
| cfg_len_en | input | 1 | Send the length byte |
| cfg_pay_len | input | LEN_W | Payload byte count |
| cfg_crc_en | input | 1 | Append the 16-bit checksum |
| cfg_crc_fmt | input | 1 | Checksum polynomial select |
| fifo_data | input | 8 | Head byte of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_pop | output | 1 | Remove the head byte this cycle |
| bit_data | output | 1 | Serial bit toward the modulator |
| bit_valid | output | 1 | bit_data is offered |
| bit_ready | input | 1 | Modulator takes the offered bit |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| underflow | output | 1 | Sticky FIFO-ran-dry flag |

## Verification
Two events can fall in the same clock edge: the acceptance of the last payload bit, and the loading of the first checksum bit, which must already include that payload bit. A second pair is the acceptance of a byte's last bit and the pop of the next byte from an empty or refilled FIFO. The sweep drives a pseudo-random ready pattern over every mix of sync length, header form, length byte, checksum format and short payload sizes, so that both boundaries land with and without back-pressure. A forced-ready run with a starved FIFO makes the stall coincide with the byte boundary. Each case is judged by comparing the whole received bit stream, including the checksum, against a stream that the bench computes arithmetically from the requirements.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
package pkt_tx_pkg;
  // Packet sections in transmit order; the encoding order is the send order.
  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_PRE  = 3'd1,
    F_SYNC = 3'd2,
    F_TRL  = 3'd3,
    F_HDR  = 3'd4,
    F_LEN  = 3'd5,
    F_PAY  = 3'd6,
    F_CRC  = 3'd7
  } fld_e;
endpackage

// File: rtl/pkt_tx_crc16.sv
`timescale 1ns/1ps
// One serial step of a 16-bit checksum with two selectable polynomials.
module pkt_tx_crc16 #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY0 = 16'h1021,
  parameter logic [15:0] POLY1 = 16'h8005
) (
  input  logic [CRC_W-1:0] crc_q,
  input  logic             din,
  input  logic             fmt,
  output logic [CRC_W-1:0] crc_d
);
  logic             fb;
  logic [CRC_W-1:0] poly;

  assign fb    = crc_q[CRC_W-1] ^ din;
  assign poly  = fmt ? CRC_W'(POLY1) : CRC_W'(POLY0);
  assign crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
endmodule

// File: rtl/pkt_tx_fieldmux.sv
`timescale 1ns/1ps
// Picks the bit for the current section and the start count of the next one.
module pkt_tx_fieldmux
  import pkt_tx_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 11
) (
  input  fld_e             fld,
  input  fld_e             nxt,
  input  logic [5:0]       cnt_lo,
  input  logic [63:0]      cfg_sync,
  input  logic [1:0]       cfg_sync_sel,
  input  logic [1:0]       cfg_pid,
  input  logic [5:0]       cfg_addr_lo,
  input  logic             cfg_addr_ext,
  input  logic [7:0]       cfg_addr_hi,
  input  logic [LEN_W-1:0] cfg_pay_len,
  input  logic             fifo_msb,
  input  logic [7:0]       pay_byte,
  input  logic             crc_top,
  output logic             cur_bit,
  output logic [CNT_W-1:0] nxt_cnt
);
  localparam int LI = $clog2(LEN_W);

  logic        sync_top;
  logic [15:0] hdr_word;

  always_comb begin
    case (cfg_sync_sel)
      2'd0:    sync_top = cfg_sync[31];
      2'd1:    sync_top = cfg_sync[47];
      default: sync_top = cfg_sync[63];
    endcase
  end

  assign hdr_word = cfg_addr_ext ? {cfg_pid, cfg_addr_lo, cfg_addr_hi}
                                 : {8'h00, cfg_pid, cfg_addr_lo};

  // Counters run down to 0, so an odd count marks an even bit position.
  always_comb begin
    case (fld)
      F_PRE:   cur_bit = sync_top ^ cnt_lo[0];
      F_SYNC:  cur_bit = cfg_sync[cnt_lo];
      F_TRL:   cur_bit = cfg_sync[0] ^ cnt_lo[0];
      F_HDR:   cur_bit = hdr_word[cnt_lo[3:0]];
      F_LEN:   cur_bit = cfg_pay_len[cnt_lo[LI-1:0]];
      F_PAY:   cur_bit = (cnt_lo[2:0] == 3'd7) ? fifo_msb : pay_byte[cnt_lo[2:0]];
      F_CRC:   cur_bit = crc_top;
      default: cur_bit = 1'b0;
    endcase
  end

  always_comb begin
    case (nxt)
      F_SYNC:  nxt_cnt = (cfg_sync_sel == 2'd0) ? CNT_W'(31) :
                         (cfg_sync_sel == 2'd1) ? CNT_W'(47) : CNT_W'(63);
      F_TRL:   nxt_cnt = CNT_W'(3);
      F_HDR:   nxt_cnt = cfg_addr_ext ? CNT_W'(15) : CNT_W'(7);
      F_LEN:   nxt_cnt = CNT_W'(LEN_W - 1);
      F_PAY:   nxt_cnt = CNT_W'({cfg_pay_len - LEN_W'(1), 3'b111});
      F_CRC:   nxt_cnt = CNT_W'(15);
      default: nxt_cnt = '0;
    endcase
  end
endmodule

// File: rtl/pkt_tx_framer.sv
`timescale 1ns/1ps
module pkt_tx_framer
  import pkt_tx_pkg::*;
#(
  parameter int          PRE_W     = 8,
  parameter int          LEN_W     = 8,
  parameter logic [15:0] CRC_POLY0 = 16'h1021,
  parameter logic [15:0] CRC_POLY1 = 16'h8005
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic [63:0]      cfg_sync,
  input  logic [1:0]       cfg_sync_sel,
  input  logic             cfg_hdr_en,
  input  logic [1:0]       cfg_pid,
  input  logic [5:0]       cfg_addr_lo,
  input  logic             cfg_addr_ext,
  input  logic [7:0]       cfg_addr_hi,
  input  logic             cfg_len_en,
  input  logic [LEN_W-1:0] cfg_pay_len,
  input  logic             cfg_crc_en,
  input  logic             cfg_crc_fmt,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_empty,
  output logic             fifo_pop,
  output logic             bit_data,
  output logic             bit_valid,
  input  logic             bit_ready,
  output logic             busy,
  output logic             done,
  output logic             underflow
);
  localparam int CNT_W = ((PRE_W > LEN_W) ? PRE_W : LEN_W) + 3;
  localparam int CRC_W = 16;

  fld_e             fld, nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic [7:0]       pay_byte;
  logic [CRC_W-1:0] crc, crc_step;
  logic             out_valid, out_bit, out_last, done_q, uflow_q;
  logic [7:0]       want;
  logic             slot_free, need_byte, load, covered, cur_bit;

  // Which sections this packet contains, indexed by section code.
  always_comb begin
    want         = '0;
    want[F_PRE]  = 1'b1;
    want[F_SYNC] = 1'b1;
    want[F_TRL]  = 1'b1;
    want[F_HDR]  = cfg_hdr_en;
    want[F_LEN]  = cfg_len_en;
    want[F_PAY]  = (cfg_pay_len != '0);
    want[F_CRC]  = cfg_crc_en;
  end

  // First wanted section after the current one; IDLE when none remains.
  always_comb begin
    nxt = F_IDLE;
    for (int k = 7; k >= 1; k--) begin
      if (k > int'(fld) && want[k]) nxt = fld_e'(3'(k));
    end
  end

  assign slot_free = !out_valid || bit_ready;
  assign need_byte = (fld == F_PAY) && (cnt[2:0] == 3'd7);
  assign load      = (fld != F_IDLE) && slot_free && !(need_byte && fifo_empty);
  assign covered   = (fld == F_HDR) || (fld == F_LEN) || (fld == F_PAY);

  pkt_tx_fieldmux #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_mux (
    .fld          (fld),
    .nxt          (nxt),
    .cnt_lo       (cnt[5:0]),
    .cfg_sync     (cfg_sync),
    .cfg_sync_sel (cfg_sync_sel),
    .cfg_pid      (cfg_pid),
    .cfg_addr_lo  (cfg_addr_lo),
    .cfg_addr_ext (cfg_addr_ext),
    .cfg_addr_hi  (cfg_addr_hi),
    .cfg_pay_len  (cfg_pay_len),
    .fifo_msb     (fifo_data[7]),
    .pay_byte     (pay_byte),
    .crc_top      (crc[CRC_W-1]),
    .cur_bit      (cur_bit),
    .nxt_cnt      (nxt_cnt)
  );

  pkt_tx_crc16 #(.CRC_W(CRC_W), .POLY0(CRC_POLY0), .POLY1(CRC_POLY1)) u_crc (
    .crc_q (crc),
    .din   (cur_bit),
    .fmt   (cfg_crc_fmt),
    .crc_d (crc_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fld       <= F_IDLE;
      cnt       <= '0;
      pay_byte  <= '0;
      crc       <= '1;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
      done_q    <= 1'b0;
      uflow_q   <= 1'b0;
    end else begin
      done_q <= out_valid && bit_ready && out_last;
      if (start && !busy) begin
        fld     <= F_PRE;
        cnt     <= CNT_W'({cfg_pre_len, 3'b111});
        crc     <= '1;
        uflow_q <= 1'b0;
      end else begin
        if (load) begin
          out_valid <= 1'b1;
          out_bit   <= cur_bit;
          out_last  <= (cnt == '0) && (nxt == F_IDLE);
          if (need_byte) pay_byte <= fifo_data;
          // The checksum advances when a bit is committed, so the first
          // checksum bit already includes the payload bit ahead of it.
          if (fld == F_CRC)  crc <= {crc[CRC_W-2:0], 1'b0};
          else if (covered)  crc <= crc_step;
          if (cnt == '0) begin
            fld <= nxt;
            cnt <= nxt_cnt;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if (bit_ready) begin
          out_valid <= 1'b0;
        end
        if (need_byte && fifo_empty && slot_free) uflow_q <= 1'b1;
      end
    end
  end

  assign fifo_pop  = load && need_byte;
  assign bit_data  = out_bit;
  assign bit_valid = out_valid;
  assign busy      = (fld != F_IDLE) || out_valid;
  assign done      = done_q;
  assign underflow = uflow_q;
endmodule

// File: rtl/pkt_tx_framer_chk.sv
`timescale 1ns/1ps
module pkt_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic bit_valid,
  input logic bit_ready,
  input logic bit_data,
  input logic busy,
  input logic done,
  input logic underflow,
  input logic fifo_pop,
  input logic fifo_empty
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !bit_valid && !done && !underflow && !fifo_pop)); // R1

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_ready) |=> bit_valid); // R9

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_ready) |=> $stable(bit_data)); // R9

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bit_valid)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bit_valid && !fifo_pop)); // R10

  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underflow && !start) |=> underflow); // R11

  AST_UFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $past(fifo_empty)); // R11
endmodule

bind pkt_tx_framer pkt_tx_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .bit_valid  (bit_valid),
  .bit_ready  (bit_ready),
  .bit_data   (bit_data),
  .busy       (busy),
  .done       (done),
  .underflow  (underflow),
  .fifo_pop   (fifo_pop),
  .fifo_empty (fifo_empty)
);

// File: tb/pkt_tx_framer_bench.sv
`timescale 1ns/1ps
module pkt_tx_framer_bench;
  localparam int PRE_W = 8;
  localparam int LEN_W = 8;
  localparam int MAXB  = 4400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic [PRE_W-1:0] cfg_pre_len = '0;
  logic [63:0]      cfg_sync = '0;
  logic [1:0]       cfg_sync_sel = '0;
  logic             cfg_hdr_en = 1'b0;
  logic [1:0]       cfg_pid = '0;
  logic [5:0]       cfg_addr_lo = '0;
  logic             cfg_addr_ext = 1'b0;
  logic [7:0]       cfg_addr_hi = '0;
  logic             cfg_len_en = 1'b0;
  logic [LEN_W-1:0] cfg_pay_len = '0;
  logic             cfg_crc_en = 1'b0;
  logic             cfg_crc_fmt = 1'b0;
  logic [7:0]       fifo_data;
  logic             fifo_empty, fifo_pop;
  logic             bit_data, bit_valid;
  logic             bit_ready = 1'b0;
  logic             busy, done, underflow;

  pkt_tx_framer #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_pkt_tx_framer (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pre_len(cfg_pre_len), .cfg_sync(cfg_sync), .cfg_sync_sel(cfg_sync_sel),
    .cfg_hdr_en(cfg_hdr_en), .cfg_pid(cfg_pid), .cfg_addr_lo(cfg_addr_lo),
    .cfg_addr_ext(cfg_addr_ext), .cfg_addr_hi(cfg_addr_hi),
    .cfg_len_en(cfg_len_en), .cfg_pay_len(cfg_pay_len),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_fmt(cfg_crc_fmt),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .bit_data(bit_data), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .busy(busy), .done(done), .underflow(underflow)
  );

  // Show-ahead FIFO model
  logic [7:0]  fq [0:255];
  logic [31:0] fhead = '0;
  logic [31:0] ftail = '0;
  int          pop_cnt = 0;
  assign fifo_empty = (fhead == ftail);
  assign fifo_data  = fq[fhead[7:0]];
  always @(posedge clk) begin
    if (fifo_pop) begin
      fhead   <= fhead + 1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  int     nchk = 0;
  int     nerr = 0;
  int     cyc = 0;
  logic   wd = 1'b0;
  logic   exp_q [0:MAXB-1];
  string  exp_tag [0:MAXB-1];
  int     exp_n = 0;
  logic   rx [0:MAXB-1];
  int     rx_n = 0;
  int     done_cnt = 0;
  int     cur_pl = 0;
  logic   force_rdy = 1'b0;
  logic [7:0]  lfsr = 8'h01;
  logic   prev_hold = 1'b0;
  logic   prev_bit = 1'b0;
  logic [15:0] bcrc;

  // Ready is updated first, then the pair that the next edge will see is observed.
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bit_ready = force_rdy | lfsr[0] | lfsr[1];
    if (!rst) begin
      if (prev_hold) begin // R9 hold under back-pressure
        nchk++;
        if (!bit_valid || bit_data !== prev_bit) begin
          nerr++;
          $display("FAIL R9 held bit: valid=%0b data=%0b expected valid=1 data=%0b",
                   bit_valid, bit_data, prev_bit);
        end
      end
      if (bit_valid && bit_ready && rx_n < MAXB) begin
        rx[rx_n] = bit_data;
        rx_n++;
      end
      if (done) done_cnt++;
      prev_hold = bit_valid && !bit_ready;
      prev_bit  = bit_data;
    end else begin
      prev_hold = 1'b0;
    end
    if (cyc > 190000 && !wd) begin
      wd = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string msg);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [7:0] pay_byte(input int idx, input int k);
    return 8'((idx * 37 + k * 11 + 5) ^ (k >> 3));
  endfunction

  task automatic push(input logic b, input string tag);
    exp_q[exp_n]   = b;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic push_c(input logic b, input string tag);
    logic fb;
    push(b, tag);
    fb   = bcrc[15] ^ b;
    bcrc = {bcrc[14:0], 1'b0};
    if (fb) bcrc = bcrc ^ (cfg_crc_fmt ? 16'h8005 : 16'h1021);
  endtask

  task automatic build_exp(input int idx);
    int          nl;
    logic        m, l0;
    logic [7:0]  hb, pb;
    logic [15:0] c;
    nl = (cfg_sync_sel == 2'd0) ? 4 : (cfg_sync_sel == 2'd1) ? 6 : 8;
    m  = cfg_sync[8 * nl - 1];
    l0 = cfg_sync[0];
    exp_n = 0;
    bcrc  = 16'hFFFF;
    for (int i = 0; i < (int'(cfg_pre_len) + 1) * 8; i++) push((i % 2 == 0) ? ~m : m, "R2");
    for (int i = 8 * nl - 1; i >= 0; i--) push(cfg_sync[i], "R3");
    for (int i = 0; i < 4; i++) push((i % 2 == 0) ? ~l0 : l0, "R4");
    if (cfg_hdr_en) begin
      hb = {cfg_pid, cfg_addr_lo};
      for (int i = 7; i >= 0; i--) push_c(hb[i], "R5");
      if (cfg_addr_ext) for (int i = 7; i >= 0; i--) push_c(cfg_addr_hi[i], "R5");
    end
    if (cfg_len_en) for (int i = LEN_W - 1; i >= 0; i--) push_c(cfg_pay_len[i], "R6");
    for (int k = 0; k < int'(cfg_pay_len); k++) begin
      pb = pay_byte(idx, k);
      for (int i = 7; i >= 0; i--) push_c(pb[i], "R7");
    end
    if (cfg_crc_en) begin
      c = bcrc;
      for (int i = 15; i >= 0; i--) push(c[i], "R8");
    end
  endtask

  task automatic fifo_push(input logic [7:0] b);
    fq[ftail[7:0]] = b;
    ftail = ftail + 1;
  endtask

  task automatic set_cfg(input int idx, input int sel, input int hm, input int le,
                         input int cm, input int pl, input int pr);
    cfg_sync     = 64'h9E37_79B9_7F4A_7C15 * 64'(idx + 1);
    cfg_sync_sel = 2'(sel);
    cfg_hdr_en   = (hm != 0);
    cfg_addr_ext = (hm == 2);
    cfg_pid      = 2'(idx);
    cfg_addr_lo  = 6'(idx * 5);
    cfg_addr_hi  = 8'(idx * 29 + 3);
    cfg_len_en   = le[0];
    cfg_crc_en   = (cm != 0);
    cfg_crc_fmt  = (cm == 2);
    cfg_pay_len  = LEN_W'(pl);
    cfg_pre_len  = PRE_W'(pr);
    cur_pl       = pl;
  endtask

  task automatic compare_packet(input int p0);
    int   bad;
    logic act;
    bad = -1;
    for (int i = 0; i < exp_n; i++) begin
      if (bad < 0 && (i >= rx_n || rx[i] !== exp_q[i])) bad = i;
    end
    nchk++;
    if (bad >= 0) begin
      nerr++;
      act = (bad < rx_n) ? rx[bad] : 1'bx;
      $display("FAIL %s stream bit %0d: actual %0b expected %0b",
               exp_tag[bad], bad, act, exp_q[bad]);
    end
    chk(rx_n == exp_n, $sformatf("R10 bit count: actual %0d expected %0d", rx_n, exp_n));
    chk(done_cnt == 1, $sformatf("R10 done pulses: actual %0d expected 1", done_cnt));
    chk(!busy, $sformatf("R10 busy after done: actual %0b expected 0", busy));
    chk(pop_cnt - p0 == cur_pl,
        $sformatf("R7 pops: actual %0d expected %0d", pop_cnt - p0, cur_pl));
  endtask

  task automatic wait_done(input int limit);
    for (int c = 0; c < limit && done_cnt == 0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_packet(input int idx, input logic dbl);
    int p0;
    @(negedge clk);
    rx_n = 0;
    done_cnt = 0;
    p0 = pop_cnt;
    build_exp(idx);
    for (int k = 0; k < cur_pl; k++) fifo_push(pay_byte(idx, k));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 30000 && done_cnt == 0; c++) begin
      @(negedge clk);
      start = dbl && (c == 12); // R10: start while busy must not disturb the stream
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    compare_packet(p0);
    chk(!underflow, $sformatf("R11 no underflow with full FIFO: actual %0b expected 0", underflow));
  endtask

  initial begin
    int idx;
    int p0;
    int plv [3];
    plv = '{0, 1, 3};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!bit_valid, $sformatf("R1 bit_valid: actual %0b expected 0", bit_valid));
    chk(!busy, $sformatf("R1 busy: actual %0b expected 0", busy));
    chk(!done, $sformatf("R1 done: actual %0b expected 0", done));
    chk(!underflow, $sformatf("R1 underflow: actual %0b expected 0", underflow));
    chk(!fifo_pop, $sformatf("R1 fifo_pop: actual %0b expected 0", fifo_pop));

    // Sweep over sync length, header form, length byte, checksum mode, payload size, preamble
    idx = 0;
    for (int sel = 0; sel < 3; sel++)
      for (int hm = 0; hm < 3; hm++)
        for (int le = 0; le < 2; le++)
          for (int cm = 0; cm < 3; cm++)
            for (int pi = 0; pi < 3; pi++)
              for (int pr = 0; pr < 2; pr++) begin
                set_cfg(idx, sel, hm, le, cm, plv[pi], pr);
                run_packet(idx, (idx % 7) == 0);
                idx++;
              end

    // Boundary: longest preamble, longest sync, extended header, longest payload
    set_cfg(400, 2, 2, 1, 2, 255, 255);
    run_packet(400, 1'b0);

    // R11: FIFO runs dry in the middle of the payload
    force_rdy = 1'b1;
    set_cfg(500, 0, 0, 0, 2, 3, 0);
    @(negedge clk);
    rx_n = 0;
    done_cnt = 0;
    p0 = pop_cnt;
    build_exp(500);
    fifo_push(pay_byte(500, 0));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 500 && !underflow; c++) @(negedge clk);
    chk(underflow, $sformatf("R11 flag on dry FIFO: actual %0b expected 1", underflow));
    repeat (6) @(negedge clk);
    chk(!bit_valid, $sformatf("R11 stalled valid: actual %0b expected 0", bit_valid));
    chk(busy, $sformatf("R11 busy while stalled: actual %0b expected 1", busy));
    chk(pop_cnt - p0 == 1, $sformatf("R11 pops while stalled: actual %0d expected 1", pop_cnt - p0));
    fifo_push(pay_byte(500, 1));
    fifo_push(pay_byte(500, 2));
    wait_done(2000);
    compare_packet(p0);
    chk(underflow, $sformatf("R11 flag held after done: actual %0b expected 1", underflow));
    force_rdy = 1'b0;

    // R11: next start clears the flag
    set_cfg(501, 1, 1, 1, 1, 2, 0);
    run_packet(501, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule